// File: doc/BRIEF.md
# Transposed-Form Fixed-Point FIR Filter

This block is a single-rate finite impulse response filter in transposed form. On each clock where the enable is high it accepts one signed fixed-point sample. That sample is multiplied by every coefficient in the same cycle. Each product is added into a chain of registered partial sums that runs from the last tap toward the first. The head of the chain is the filter output, so the output is registered and keeps full precision.

The coefficients are fixed when the block is built and are passed in as one packed parameter vector. A tap whose coefficient is zero is built as a plain register that forwards the partial sum from its neighbour, with no multiplier and no adder. This makes sparse coefficient sets cheaper in area. The block never rounds, saturates, decimates or interpolates: the output word is the full accumulator.

The default build has 45 taps, a 10-bit input and 15-bit coefficients, and nine of the default coefficients are zero.

Top module: `fir_transposed`

## Requirements
- R1: After an enabled clock edge, `y_out` equals the sum over k of h[k]·x[n−k]. Here x[n] is the sample taken at that edge, x[n−k] is the sample taken k enabled edges earlier, and samples taken before the last reset count as zero.
- R2: The output is registered. The result that includes sample x[n] appears on `y_out` right after the enabled edge that takes x[n], and it stays there until the next enabled edge or the next reset edge.
- R3: The output width is `DATA_W + COEF_W + clog2(NUM_TAPS)` (31 bits by default). The result is exact for every input sequence, including the extreme-magnitude sequences whose signs match the coefficient signs.
- R4: A clock edge with `rst` high clears every partial-sum register. `y_out` is 0 after that edge, and no earlier sample affects any later output.
- R5: The first enabled edge after a reset gives `y_out` = h[0]·x, where x is the sample taken at that edge.
- R6: A clock edge with `en` low and `rst` low changes no state. `y_out` keeps its value, and the `x_in` value present at that edge never shows up in any later output.
- R7: A tap with a zero coefficient forwards the partial sum from the tap after it, unchanged, on each enabled edge. At such a tap the impulse response is exactly 0.
- R8: An impulse of value v followed by zeros gives v·h[0], v·h[1], …, v·h[NUM_TAPS−1] on consecutive enabled edges, and 0 after that.
- R9: `x_in` and each coefficient are two's complement. Coefficient h[k] sits in bits [k·COEF_W +: COEF_W] of `COEF_VEC`. Bit 0 holds the lowest bit of h[0], which is the tap applied to the newest sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of all partial sums |
| en | input | 1 | Clock enable: a sample is taken and the chain advances only when high |
| x_in | input | DATA_W | Signed input sample |
| y_out | output | DATA_W+COEF_W+clog2(NUM_TAPS) | Signed full-precision filter output |

## Verification
A wrong partial-sum register or a miswired tap shows up at `y_out` within at most NUM_TAPS enabled samples. An impulse makes this precise: the response shows the faulty tap at its own position in the sequence, so a zero tap that does not forward shows as a missing coefficient there. A mistake in the enable or reset path shows on the very next edge, because the output either moves while it should hold or keeps old energy when it should read zero. Extreme-sign sequences push the top bits of the sum, so a too-narrow or unsigned accumulator shows up as a wrong value on the 45th sample.

// File: rtl/fir_pkg.sv
package fir_pkg;

  localparam int DEF_TAPS   = 45;
  localparam int DEF_COEF_W = 15;

  // Default band-pass-like coefficient set; several taps are zero.
  localparam int DEF_COEF_LIST [DEF_TAPS] = '{
        12,   -40,     0,   215,  -610,     0,  1490, -2875,  3920, -3100,
         0,  4480, -9870, 14200,-16384, 11950, -3020, -5640,  9810, -8120,
      2750,     0,  1980, -3010,  2110,  -640,     0,   505,  -720,   430,
         0,  -118,   250,  -200,     0,    96,   -77,    31,     0,   -18,
        22,    -9,     0,     4,    -2
  };

  function automatic logic [DEF_TAPS*DEF_COEF_W-1:0] def_coef_vec();
    logic [DEF_TAPS*DEF_COEF_W-1:0] v;
    v = '0;
    for (int i = 0; i < DEF_TAPS; i++) begin
      v[i*DEF_COEF_W +: DEF_COEF_W] = DEF_COEF_W'(DEF_COEF_LIST[i]);
    end
    return v;
  endfunction

endpackage

// File: rtl/fir_mult.sv
module fir_mult #(
  parameter int A_W = 10,
  parameter int B_W = 15
) (
  input  logic signed [A_W-1:0]     a,
  input  logic signed [B_W-1:0]     b,
  output logic signed [A_W+B_W-1:0] p
);

  // Full-precision signed product, no truncation.
  assign p = a * b;

endmodule

// File: rtl/fir_stage.sv
module fir_stage #(
  parameter int                 DATA_W = 10,
  parameter int                 COEF_W = 15,
  parameter int                 ACC_W  = 31,
  parameter logic [COEF_W-1:0]  COEF   = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [ACC_W-1:0]  sum_in,
  output logic signed [ACC_W-1:0]  sum_q
);

  localparam int PROD_W = DATA_W + COEF_W;

  generate
    if (COEF == '0) begin : g_pass
      // Zero coefficient: register only, no multiplier, no adder (R7).
      always_ff @(posedge clk) begin
        if (rst)     sum_q <= '0;
        else if (en) sum_q <= sum_in;
      end

      assert_zero_tap_forward_R7: assert property (@(posedge clk) disable iff (rst)
        en |=> sum_q == $past(sum_in));
    end else begin : g_mac
      logic signed [PROD_W-1:0] prod;

      fir_mult #(.A_W(DATA_W), .B_W(COEF_W)) u_mult (
        .a (x_in),
        .b (COEF),
        .p (prod)
      );

      always_ff @(posedge clk) begin
        if (rst)     sum_q <= '0;
        else if (en) sum_q <= sum_in + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
      end
    end
  endgenerate

  assert_stage_clear_R4: assert property (@(posedge clk)
    rst |=> sum_q == '0);

  assert_stage_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sum_q));

endmodule

// File: rtl/fir_transposed.sv
module fir_transposed #(
  parameter int                           DATA_W   = 10,
  parameter int                           COEF_W   = fir_pkg::DEF_COEF_W,
  parameter int                           NUM_TAPS = fir_pkg::DEF_TAPS,
  parameter logic [NUM_TAPS*COEF_W-1:0]   COEF_VEC = fir_pkg::def_coef_vec(),
  localparam int                          ACC_W    = DATA_W + COEF_W + $clog2(NUM_TAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] x_in,
  output logic signed [ACC_W-1:0]  y_out
);

  // chain[k] is the register of tap k; chain[NUM_TAPS] is the zero tail.
  logic signed [ACC_W-1:0] chain [NUM_TAPS+1];

  assign chain[NUM_TAPS] = '0;

  generate
    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
      fir_stage #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .ACC_W  (ACC_W),
        .COEF   (COEF_VEC[k*COEF_W +: COEF_W])
      ) u_stage (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .x_in   (x_in),
        .sum_in (chain[k+1]),
        .sum_q  (chain[k])
      );
    end
  endgenerate

  assign y_out = chain[0];

  // ---------------- assertions ----------------
  function automatic longint coef_abs_sum();
    longint s;
    longint c;
    s = 0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      c = longint'($signed(COEF_VEC[k*COEF_W +: COEF_W]));
      s += (c < 0) ? -c : c;
    end
    return s;
  endfunction

  localparam longint BOUND = coef_abs_sum() * (longint'(1) << (DATA_W-1));

  logic signed [COEF_W-1:0]        h0;
  logic signed [DATA_W+COEF_W-1:0] first_prod;
  logic                            fresh;

  assign h0         = COEF_VEC[COEF_W-1:0];
  assign first_prod = h0 * x_in;

  always_ff @(posedge clk) begin
    if (rst)     fresh <= 1'b1;
    else if (en) fresh <= 1'b0;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (longint'(y_out) <= BOUND) && (longint'(y_out) >= -BOUND));

  assert_first_output_R5: assert property (@(posedge clk) disable iff (rst)
    (fresh && en) |=> longint'(y_out) == longint'($past(first_prod)));

  assert_output_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(y_out));

  assert_output_clear_R4: assert property (@(posedge clk)
    rst |=> y_out == '0);

endmodule

// File: tb/tb_fir_transposed.sv
module tb_fir_transposed;

  localparam int DATA_W = 10;
  localparam int NT     = fir_pkg::DEF_TAPS;
  localparam int ACC_W  = DATA_W + fir_pkg::DEF_COEF_W + $clog2(NT);

  typedef struct {
    longint value;
    string  tag;
  } item_t;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     en  = 1'b0;
  logic signed [DATA_W-1:0] x_in = '0;
  logic signed [ACC_W-1:0]  y_out;

  int     checks = 0;
  int     errors = 0;
  bit     done   = 1'b0;
  item_t  expq[$];
  longint hist[$];
  string  cur_tag = "R4";
  longint last_y  = 0;

  always #10 clk = ~clk;

  fir_transposed dut (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .x_in  (x_in),
    .y_out (y_out)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: y_out=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Direct-form reference over all samples taken since the last reset.
  function automatic longint conv();
    longint s;
    int n;
    s = 0;
    n = hist.size();
    for (int k = 0; k < NT && k < n; k++) begin
      s += longint'(fir_pkg::DEF_COEF_LIST[k]) * hist[n-1-k];
    end
    return s;
  endfunction

  task automatic drive(input bit e, input longint x);
    item_t it;
    @(negedge clk);
    rst  = 1'b0;
    en   = e;
    x_in = DATA_W'(x);
    if (e) begin
      hist.push_back(x);
      it.value = conv();
      it.tag   = (hist.size() == 1) ? {cur_tag, " R5"} : cur_tag;
      expq.push_back(it);
    end
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst  = 1'b1;
    en   = 1'b1;
    x_in = 10'sd300;
    repeat (n) @(negedge clk);
    hist.delete();
  endtask

  // Monitor: check each cycle's outcome away from the edge.
  initial begin
    bit was_rst;
    bit was_en;
    item_t it;
    forever begin
      @(posedge clk);
      was_rst = rst;
      was_en  = en;
      #5;
      if (was_rst) begin
        check("R4 reset clears", longint'(y_out), 0);
      end else if (was_en) begin
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R1: output with no expected item, y_out=%0d expected=none", longint'(y_out));
        end else begin
          it = expq.pop_front();
          check(it.tag, longint'(y_out), it.value);
        end
      end else begin
        check("R6 hold with enable low", longint'(y_out), last_y);
      end
      last_y = longint'(y_out);
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint xs;
    // R4: reset state
    do_reset(3);

    // R8 R7 R2: positive full-scale impulse, then zeros
    cur_tag = "R8 R7 R2 impulse";
    drive(1'b1, 511);
    for (int i = 0; i < NT + 3; i++) drive(1'b1, 0);

    // R9 R8: negative impulse after a reset
    do_reset(1);
    cur_tag = "R9 R8 negative impulse";
    drive(1'b1, -512);
    for (int i = 0; i < NT + 2; i++) drive(1'b1, 0);

    // R3: extreme sequences matching and opposing coefficient signs
    for (int pol = 0; pol < 2; pol++) begin
      do_reset(2);
      cur_tag = "R3 extreme magnitude";
      for (int j = 0; j < NT; j++) begin
        longint h;
        h  = fir_pkg::DEF_COEF_LIST[NT-1-j];
        xs = (h == 0) ? 0 : (((h > 0) ^ (pol == 1)) ? 511 : -512);
        drive(1'b1, xs);
      end
      drive(1'b1, 0);
    end

    // R1: random samples with enable always high
    do_reset(1);
    cur_tag = "R1 random stream";
    for (int i = 0; i < 150; i++) drive(1'b1, longint'($urandom_range(0, 1023)) - 512);

    // R6: random samples with enable gaps; gap samples must not leak
    cur_tag = "R6 R1 gated stream";
    for (int i = 0; i < 200; i++) begin
      bit e;
      e = ($urandom_range(0, 3) != 0);
      drive(e, longint'($urandom_range(0, 1023)) - 512);
    end

    // R4 R5: reset in the middle of a stream, then a single sample
    do_reset(1);
    cur_tag = "R4 after mid-stream reset";
    drive(1'b1, 77);
    drive(1'b0, 400);
    drive(1'b0, -300);
    drive(1'b1, -5);
    for (int i = 0; i < 5; i++) drive(1'b1, 0);

    drive(1'b0, 0);
    repeat (3) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d results missing, actual=%0d expected=0", expq.size(), expq.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule